// File: doc/BRIEF.md
# Delayed Branch Resolution Unit

This unit settles every control transfer of a single-issue core that has one delay slot. For each branch or jump it is given the class of the instruction and its operands. It returns the decision, the destination address and any return-address write. It also flags reserved encodings. A branch that is going to run its delay-slot instruction is held as pending inside the unit. The fetch redirect is issued only when the core reports that the delay-slot instruction has retired.

A likely-form branch whose condition fails does not use its delay slot. The unit asks for that slot to be squashed and redirects fetch straight past it. A control transfer that arrives while a branch is already pending sits in a delay slot. The unit flags it and drops it, and the pending branch keeps its redirect. Targets come from three sources: the program counter plus an offset, a page-relative index, or the value of a register. The register value is captured when the branch issues.

Top module: `brc_top`

## Requirements
- R1: Kind codes on `br_kind_i` are: 0 equal, 1 not-equal, 2 at-or-below-zero, 3 above-zero, 4 below-zero, 5 at-or-above-zero, 6 below-zero-and-link, 7 at-or-above-zero-and-link, 8 jump, 9 jump-and-link, 10 jump-register, 11 jump-register-and-link. For kinds 0 to 7 the target is pc+4 plus the 16-bit offset, sign-extended and shifted left by two.
- R2: For kinds 8 and 9 the target is bits 31:28 of pc+4, followed by the 26-bit index, followed by two zero bits.
- R3: For kinds 10 and 11 the target is `rs_val_i` as sampled in the issue cycle. A later change of `rs_val_i` does not alter the redirect.
- R4: All conditions compare signed 32-bit values: `rs` against `rt` for kinds 0 and 1, and `rs` against zero for kinds 2 to 7. Kinds 8 to 11 are always taken.
- R5: Kinds 6, 7 and 9 write pc+8 to register 31. Kind 11 writes pc+8 to `rd_num_i`, and when that register is 0 no write is made. The write happens whether or not the branch is taken, and also for likely forms.
- R6: The reserved cases are: a nonzero `hint_i` on kind 10 or 11, any kind from 12 to 15, and `br_likely_i` set on kinds 8 to 11. Each one raises `ri_o` for one cycle and gives no decision, no link write, no squash and no redirect.
- R7: A taken branch without the likely flag has its redirect to the target delayed. `redir_valid_o` pulses only in the cycle after `slot_done_i` is sampled.
- R8: A branch that is not taken and has no likely flag produces no redirect when its slot retires.
- R9: A likely branch (`br_likely_i`=1) that is not taken pulses `squash_o` together with a redirect to pc+8 in the cycle after issue. It leaves nothing pending.
- R10: A likely branch that is taken behaves like R7: no squash, and the redirect follows slot retirement.
- R11: A branch that issues while another is pending pulses `nest_o` and is otherwise ignored. The first branch's redirect is the one delivered.
- R12: After reset every output is zero. A `slot_done_i` pulse with nothing pending has no effect.
- R13: The decision, target, link and reserved outputs are registered. They are valid for the single cycle after the issue cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid_i | input | 1 | Control transfer issues this cycle |
| br_kind_i | input | 4 | Instruction class code |
| br_likely_i | input | 1 | Likely form (slot nullified when not taken) |
| rs_val_i | input | 32 | First source value |
| rt_val_i | input | 32 | Second source value |
| br_off_i | input | 16 | Raw PC-relative offset |
| jidx_i | input | 26 | Page-relative jump index |
| hint_i | input | 5 | Hint field of register jumps |
| rd_num_i | input | 5 | Link destination for kind 11 |
| pc_i | input | 32 | Address of the branch |
| slot_done_i | input | 1 | Delay-slot instruction retired |
| dec_valid_o | output | 1 | Decision valid |
| dec_taken_o | output | 1 | Branch taken |
| dec_target_o | output | 32 | Computed target |
| link_we_o | output | 1 | Link register write |
| link_reg_o | output | 5 | Link register number |
| link_val_o | output | 32 | Link value (pc+8) |
| ri_o | output | 1 | Reserved instruction |
| squash_o | output | 1 | Nullify the delay slot |
| nest_o | output | 1 | Branch seen inside a delay slot |
| redir_valid_o | output | 1 | Fetch redirect |
| redir_pc_o | output | 32 | Redirect address |

## Verification
The hardest case to reach is a register jump whose source value changes between issue and slot retirement, combined with a second control transfer landing in the delay slot. Random stimulus rarely lines these up. The bench therefore inverts `rs_val_i` before asserting `slot_done_i` on every pending branch, so a target that is sampled late would show up as a wrong redirect. It also runs directed sequences that issue a second branch while the first is pending and check that only the first redirect comes out. Signed boundaries such as 0x80000000 against zero are driven explicitly.

// File: rtl/brc_pkg.sv
package brc_pkg;
  localparam logic [3:0] K_BEQ    = 4'd0;
  localparam logic [3:0] K_BNE    = 4'd1;
  localparam logic [3:0] K_BLEZ   = 4'd2;
  localparam logic [3:0] K_BGTZ   = 4'd3;
  localparam logic [3:0] K_BLTZ   = 4'd4;
  localparam logic [3:0] K_BGEZ   = 4'd5;
  localparam logic [3:0] K_BLTZAL = 4'd6;
  localparam logic [3:0] K_BGEZAL = 4'd7;
  localparam logic [3:0] K_J      = 4'd8;
  localparam logic [3:0] K_JAL    = 4'd9;
  localparam logic [3:0] K_JR     = 4'd10;
  localparam logic [3:0] K_JALR   = 4'd11;

  typedef struct packed {
    logic is_cond;   // compares operands
    logic is_abs;    // page-relative index target
    logic is_reg;    // register target
    logic is_link;   // writes return address
    logic link_rd;   // link goes to rd field
    logic rsv;       // reserved encoding
  } brc_dec_t;
endpackage

// File: rtl/brc_decode.sv
module brc_decode
  import brc_pkg::*;
#(
  parameter int HINTW = 5
) (
  input  logic [3:0]       kind_i,
  input  logic             likely_i,
  input  logic [HINTW-1:0] hint_i,
  output brc_dec_t         dec_o
);
  always_comb begin
    dec_o = '0;
    unique case (kind_i)
      K_BEQ, K_BNE, K_BLEZ, K_BGTZ, K_BLTZ, K_BGEZ: dec_o.is_cond = 1'b1;
      K_BLTZAL, K_BGEZAL: begin
        dec_o.is_cond = 1'b1;
        dec_o.is_link = 1'b1;
      end
      K_J: dec_o.is_abs = 1'b1;
      K_JAL: begin
        dec_o.is_abs  = 1'b1;
        dec_o.is_link = 1'b1;
      end
      K_JR: dec_o.is_reg = 1'b1;
      K_JALR: begin
        dec_o.is_reg  = 1'b1;
        dec_o.is_link = 1'b1;
        dec_o.link_rd = 1'b1;
      end
      default: dec_o.rsv = 1'b1;
    endcase
    if (!dec_o.is_cond && likely_i) dec_o.rsv = 1'b1;
    if (dec_o.is_reg && (hint_i != '0)) dec_o.rsv = 1'b1;
  end
endmodule

// File: rtl/brc_cond.sv
module brc_cond
  import brc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [3:0]      kind_i,
  input  logic [XLEN-1:0] rs_i,
  input  logic [XLEN-1:0] rt_i,
  output logic            take_o
);
  logic signed [XLEN-1:0] rs_s;
  logic                   neg, zero;

  assign rs_s = $signed(rs_i);
  assign neg  = rs_s < 0;
  assign zero = (rs_i == '0);

  always_comb begin
    unique case (kind_i)
      K_BEQ:              take_o = (rs_i == rt_i);
      K_BNE:              take_o = (rs_i != rt_i);
      K_BLEZ:             take_o = neg | zero;
      K_BGTZ:             take_o = ~neg & ~zero;
      K_BLTZ, K_BLTZAL:   take_o = neg;
      K_BGEZ, K_BGEZAL:   take_o = ~neg;
      default:            take_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/brc_target.sv
module brc_target #(
  parameter int XLEN  = 32,
  parameter int OFFW  = 16,
  parameter int JIDXW = 26
) (
  input  logic [XLEN-1:0]  pc_i,
  input  logic [OFFW-1:0]  off_i,
  input  logic [JIDXW-1:0] jidx_i,
  input  logic [XLEN-1:0]  rs_i,
  input  logic             is_abs_i,
  input  logic             is_reg_i,
  output logic [XLEN-1:0]  target_o,
  output logic [XLEN-1:0]  pc8_o
);
  localparam int SEXTW = XLEN - OFFW - 2;
  localparam int PAGEW = XLEN - JIDXW - 2;

  logic [XLEN-1:0] pc4, rel, abs_t;

  assign pc4   = pc_i + XLEN'(4);
  assign pc8_o = pc_i + XLEN'(8);
  assign rel   = pc4 + {{SEXTW{off_i[OFFW-1]}}, off_i, 2'b00};
  assign abs_t = {pc4[XLEN-1 -: PAGEW], jidx_i, 2'b00};

  always_comb begin
    if (is_reg_i)      target_o = rs_i;
    else if (is_abs_i) target_o = abs_t;
    else               target_o = rel;
  end
endmodule

// File: rtl/brc_pend.sv
module brc_pend #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            arm_i,
  input  logic            taken_i,
  input  logic [XLEN-1:0] target_i,
  input  logic            slot_done_i,
  output logic            pend_o,
  output logic            fire_o,
  output logic [XLEN-1:0] fire_pc_o
);
  logic            taken_q;
  logic [XLEN-1:0] tgt_q;

  assign fire_o    = pend_o & slot_done_i & taken_q;
  assign fire_pc_o = tgt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_o  <= 1'b0;
      taken_q <= 1'b0;
      tgt_q   <= '0;
    end else if (arm_i) begin
      pend_o  <= 1'b1;
      taken_q <= taken_i;
      tgt_q   <= target_i;
    end else if (slot_done_i) begin
      pend_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/brc_top.sv
module brc_top
  import brc_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int OFFW     = 16,
  parameter int JIDXW    = 26,
  parameter int REGW     = 5,
  parameter int LINK_REG = 31
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             br_valid_i,
  input  logic [3:0]       br_kind_i,
  input  logic             br_likely_i,
  input  logic [XLEN-1:0]  rs_val_i,
  input  logic [XLEN-1:0]  rt_val_i,
  input  logic [OFFW-1:0]  br_off_i,
  input  logic [JIDXW-1:0] jidx_i,
  input  logic [REGW-1:0]  hint_i,
  input  logic [REGW-1:0]  rd_num_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic             slot_done_i,
  output logic             dec_valid_o,
  output logic             dec_taken_o,
  output logic [XLEN-1:0]  dec_target_o,
  output logic             link_we_o,
  output logic [REGW-1:0]  link_reg_o,
  output logic [XLEN-1:0]  link_val_o,
  output logic             ri_o,
  output logic             squash_o,
  output logic             nest_o,
  output logic             redir_valid_o,
  output logic [XLEN-1:0]  redir_pc_o
);
  brc_dec_t        dec;
  logic            take;
  logic [XLEN-1:0] target, pc8, fire_pc;
  logic            pend, fire;
  logic            accept, go, skip, arm;
  logic [REGW-1:0] link_dst;

  brc_decode #(.HINTW(REGW)) u_dec (
    .kind_i(br_kind_i), .likely_i(br_likely_i), .hint_i(hint_i), .dec_o(dec)
  );

  brc_cond #(.XLEN(XLEN)) u_cond (
    .kind_i(br_kind_i), .rs_i(rs_val_i), .rt_i(rt_val_i), .take_o(take)
  );

  brc_target #(.XLEN(XLEN), .OFFW(OFFW), .JIDXW(JIDXW)) u_tgt (
    .pc_i(pc_i), .off_i(br_off_i), .jidx_i(jidx_i), .rs_i(rs_val_i),
    .is_abs_i(dec.is_abs), .is_reg_i(dec.is_reg),
    .target_o(target), .pc8_o(pc8)
  );

  assign accept   = br_valid_i & ~pend;
  assign go       = accept & ~dec.rsv;
  assign skip     = go & br_likely_i & ~take;
  assign arm      = go & ~skip;
  assign link_dst = dec.link_rd ? rd_num_i : REGW'(LINK_REG);

  brc_pend #(.XLEN(XLEN)) u_pend (
    .clk(clk), .rst(rst), .arm_i(arm), .taken_i(take), .target_i(target),
    .slot_done_i(slot_done_i), .pend_o(pend), .fire_o(fire), .fire_pc_o(fire_pc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid_o   <= 1'b0;
      dec_taken_o   <= 1'b0;
      dec_target_o  <= '0;
      link_we_o     <= 1'b0;
      link_reg_o    <= '0;
      link_val_o    <= '0;
      ri_o          <= 1'b0;
      squash_o      <= 1'b0;
      nest_o        <= 1'b0;
      redir_valid_o <= 1'b0;
      redir_pc_o    <= '0;
    end else begin
      dec_valid_o   <= go;
      dec_taken_o   <= go & take;
      dec_target_o  <= target;
      link_we_o     <= go & dec.is_link & (link_dst != '0);
      link_reg_o    <= link_dst;
      link_val_o    <= pc8;
      ri_o          <= accept & dec.rsv;
      squash_o      <= skip;
      nest_o        <= br_valid_i & pend;
      redir_valid_o <= skip | fire;
      redir_pc_o    <= skip ? pc8 : fire_pc;
    end
  end
endmodule

// File: rtl/brc_chk.sv
module brc_chk (
  input logic        clk,
  input logic        rst,
  input logic        br_valid_i,
  input logic        slot_done_i,
  input logic        dec_valid_o,
  input logic        link_we_o,
  input logic [4:0]  link_reg_o,
  input logic        ri_o,
  input logic        squash_o,
  input logic        nest_o,
  input logic        redir_valid_o
);
  // R9
  squash_redir_chk: assert property (@(posedge clk) disable iff (rst)
    squash_o |-> redir_valid_o);
  // R6
  ri_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ri_o |-> (!dec_valid_o && !link_we_o && !squash_o && !redir_valid_o));
  // R11
  nest_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    nest_o |-> (!dec_valid_o && !link_we_o && !ri_o));
  // R7
  redir_after_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (redir_valid_o && !squash_o) |-> $past(slot_done_i));
  // R5
  link_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    link_we_o |-> (link_reg_o != 5'd0));
  // R13
  dec_after_issue_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_valid_o || ri_o) |-> $past(br_valid_i));
endmodule

bind brc_top brc_chk u_chk (
  .clk(clk), .rst(rst), .br_valid_i(br_valid_i), .slot_done_i(slot_done_i),
  .dec_valid_o(dec_valid_o), .link_we_o(link_we_o), .link_reg_o(link_reg_o),
  .ri_o(ri_o), .squash_o(squash_o), .nest_o(nest_o), .redir_valid_o(redir_valid_o)
);

// File: tb/brc_top_tb.sv
module brc_top_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        br_valid_i = 1'b0;
  logic [3:0]  br_kind_i = '0;
  logic        br_likely_i = 1'b0;
  logic [31:0] rs_val_i = '0, rt_val_i = '0, pc_i = '0;
  logic [15:0] br_off_i = '0;
  logic [25:0] jidx_i = '0;
  logic [4:0]  hint_i = '0, rd_num_i = '0;
  logic        slot_done_i = 1'b0;
  logic        dec_valid_o, dec_taken_o, link_we_o, ri_o, squash_o, nest_o, redir_valid_o;
  logic [31:0] dec_target_o, link_val_o, redir_pc_o;
  logic [4:0]  link_reg_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  brc_top u_dut (
    .clk(clk), .rst(rst), .br_valid_i(br_valid_i), .br_kind_i(br_kind_i),
    .br_likely_i(br_likely_i), .rs_val_i(rs_val_i), .rt_val_i(rt_val_i),
    .br_off_i(br_off_i), .jidx_i(jidx_i), .hint_i(hint_i), .rd_num_i(rd_num_i),
    .pc_i(pc_i), .slot_done_i(slot_done_i), .dec_valid_o(dec_valid_o),
    .dec_taken_o(dec_taken_o), .dec_target_o(dec_target_o), .link_we_o(link_we_o),
    .link_reg_o(link_reg_o), .link_val_o(link_val_o), .ri_o(ri_o),
    .squash_o(squash_o), .nest_o(nest_o), .redir_valid_o(redir_valid_o),
    .redir_pc_o(redir_pc_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit f_rsv(input [3:0] k, input bit l, input [4:0] hn);
    return (k >= 12) || (l && k >= 8) || ((k == 10 || k == 11) && hn != 0);
  endfunction

  function automatic bit f_take(input [3:0] k, input [31:0] rs, input [31:0] rt);
    case (k)
      0: return rs == rt;
      1: return rs != rt;
      2: return $signed(rs) <= 0;
      3: return $signed(rs) > 0;
      4, 6: return $signed(rs) < 0;
      5, 7: return $signed(rs) >= 0;
      default: return 1'b1;
    endcase
  endfunction

  function automatic [31:0] f_tgt(input [3:0] k, input [31:0] p, input [15:0] off,
                                  input [25:0] ji, input [31:0] rs);
    logic [31:0] p4;
    p4 = p + 32'd4;
    if (k == 10 || k == 11) return rs;
    if (k == 8 || k == 9) return {p4[31:28], ji, 2'b00};
    return p4 + ({{16{off[15]}}, off} << 2);
  endfunction

  task automatic do_branch(input [3:0] k, input bit l, input [31:0] rs, input [31:0] rt,
                           input [15:0] off, input [25:0] ji, input [4:0] hn,
                           input [4:0] rd, input [31:0] p, input bit nest_it);
    bit rsv, tk, lnk, skip, pend;
    logic [31:0] tgt;
    logic [4:0] lreg;
    rsv  = f_rsv(k, l, hn);
    tk   = f_take(k, rs, rt);
    tgt  = f_tgt(k, p, off, ji, rs);
    lreg = (k == 11) ? rd : 5'd31;
    lnk  = !rsv && (k == 6 || k == 7 || k == 9 || (k == 11 && rd != 0));
    skip = !rsv && l && !tk;
    pend = !rsv && !skip;
    @(negedge clk);
    br_valid_i = 1'b1; br_kind_i = k; br_likely_i = l; rs_val_i = rs; rt_val_i = rt;
    br_off_i = off; jidx_i = ji; hint_i = hn; rd_num_i = rd; pc_i = p;
    @(negedge clk);
    br_valid_i = 1'b0;
    // R13 / R6: registered decision
    chk(ri_o == rsv, "R6 ri", {31'd0, ri_o}, {31'd0, rsv});
    chk(dec_valid_o == !rsv, "R13 dec_valid", {31'd0, dec_valid_o}, {31'd0, !rsv});
    if (!rsv) begin
      // R4 signed conditions
      chk(dec_taken_o == tk, "R4 taken", {31'd0, dec_taken_o}, {31'd0, tk});
      // R1 R2 R3 targets
      chk(dec_target_o == tgt, (k >= 10) ? "R3 target" : (k >= 8) ? "R2 target" : "R1 target",
          dec_target_o, tgt);
    end
    // R5 link
    chk(link_we_o == lnk, "R5 link_we", {31'd0, link_we_o}, {31'd0, lnk});
    if (lnk) begin
      chk(link_reg_o == lreg && link_val_o == p + 32'd8, "R5 link value",
          link_val_o, p + 32'd8);
    end
    // R9 squash and early redirect
    chk(squash_o == skip, "R9 squash", {31'd0, squash_o}, {31'd0, skip});
    chk(redir_valid_o == skip, "R7 no early redirect", {31'd0, redir_valid_o}, {31'd0, skip});
    if (skip) chk(redir_pc_o == p + 32'd8, "R9 redirect pc", redir_pc_o, p + 32'd8);
    if (pend) begin
      rs_val_i = ~rs;   // R3: late change must not matter
      if (nest_it) begin
        br_valid_i = 1'b1; br_kind_i = 4'd8; br_likely_i = 1'b0;
        jidx_i = ~ji; pc_i = p + 32'd4;
        @(negedge clk);
        br_valid_i = 1'b0;
        chk(nest_o == 1'b1, "R11 nest flag", {31'd0, nest_o}, 32'd1);
        chk(dec_valid_o == 1'b0 && link_we_o == 1'b0, "R11 ignored",
            {31'd0, dec_valid_o}, 32'd0);
      end else begin
        @(negedge clk);
      end
      chk(redir_valid_o == 1'b0, "R7 wait for slot", {31'd0, redir_valid_o}, 32'd0);
      slot_done_i = 1'b1;
      @(negedge clk);
      slot_done_i = 1'b0;
      chk(redir_valid_o == tk, tk ? (l ? "R10 redirect" : "R7 redirect") : "R8 no redirect",
          {31'd0, redir_valid_o}, {31'd0, tk});
      chk(squash_o == 1'b0, "R10 no squash", {31'd0, squash_o}, 32'd0);
      if (tk) chk(redir_pc_o == tgt, (k >= 10) ? "R3 redirect pc" : "R7 redirect pc",
                  redir_pc_o, tgt);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R12 reset state
    chk({dec_valid_o, link_we_o, ri_o, squash_o, nest_o, redir_valid_o} == 6'd0,
        "R12 reset outputs", {26'd0, dec_valid_o, link_we_o, ri_o, squash_o, nest_o, redir_valid_o}, 32'd0);
    slot_done_i = 1'b1;
    @(negedge clk);
    slot_done_i = 1'b0;
    chk(redir_valid_o == 1'b0, "R12 idle slot_done", {31'd0, redir_valid_o}, 32'd0);

    // directed corners
    do_branch(4'd2, 1'b0, 32'h8000_0000, 0, 16'hFFFF, 0, 0, 0, 32'h0000_1000, 1'b0); // R4 signed
    do_branch(4'd3, 1'b0, 32'h8000_0000, 0, 16'h0010, 0, 0, 0, 32'h0000_2000, 1'b0); // R8
    do_branch(4'd0, 1'b1, 32'd5, 32'd6, 16'h0004, 0, 0, 0, 32'h0000_3000, 1'b0);     // R9
    do_branch(4'd1, 1'b1, 32'd5, 32'd6, 16'h8000, 0, 0, 0, 32'h0004_0000, 1'b0);     // R10
    do_branch(4'd6, 1'b1, 32'd1, 0, 16'h0008, 0, 0, 0, 32'h0000_4000, 1'b0);         // R5 likely link not taken
    do_branch(4'd9, 1'b0, 0, 0, 0, 26'h3FF_FFFF, 0, 0, 32'hAFFF_FFFC, 1'b0);         // R2 page carry
    do_branch(4'd11, 1'b0, 32'h1234_5678, 0, 0, 0, 0, 5'd0, 32'h100, 1'b0);          // R5 rd=0
    do_branch(4'd11, 1'b0, 32'h1234_5678, 0, 0, 0, 0, 5'd7, 32'h100, 1'b0);          // R3 R5
    do_branch(4'd10, 1'b0, 32'h1234_5678, 0, 0, 0, 5'd3, 0, 32'h100, 1'b0);          // R6 hint
    do_branch(4'd13, 1'b0, 0, 0, 0, 0, 0, 0, 32'h200, 1'b0);                         // R6 kind
    do_branch(4'd8, 1'b1, 0, 0, 0, 26'h1, 0, 0, 32'h300, 1'b0);                      // R6 likely jump
    do_branch(4'd0, 1'b0, 32'd9, 32'd9, 16'h0020, 0, 0, 0, 32'h500, 1'b1);           // R11

    // constrained random
    for (int i = 0; i < 400; i++) begin
      logic [31:0] rs, rt;
      logic [3:0]  k;
      case ($urandom % 4)
        0: rs = 32'd0;
        1: rs = 32'hFFFF_FFFF;
        2: rs = 32'd1;
        default: rs = $urandom;
      endcase
      rt = ($urandom % 2) ? rs : $urandom;
      k  = ($urandom % 8 == 0) ? 4'($urandom % 16) : 4'($urandom % 12);
      do_branch(k, ($urandom % 3) == 0, rs, rt, 16'($urandom), 26'($urandom),
                (($urandom % 8) == 0) ? 5'($urandom % 31 + 1) : 5'd0,
                5'($urandom), {$urandom} & 32'hFFFF_FFFC, ($urandom % 6) == 0);
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule